// File: doc/BRIEF.md
# Quasi-Bidirectional General-Purpose Port

This block is an 8-bit general-purpose port with no direction register. Each pin has one output latch bit and behaves as an open-drain driver. A latch bit of 0 pulls the pin hard low. A latch bit of 1 releases the pin, and any outside device may then pull it low. A released pin reads high only through a weak pull-up, which a parameter includes or leaves out, or through an external resistor. To use a pin as an input, software writes 1 to its latch bit and then reads the pin.

The processor side offers four kinds of access:
- a whole-byte write;
- set, clear or invert of one bit, chosen by index;
- an indivisible AND, OR or XOR of the latch with an operand;
- byte and single-bit reads of the pin levels.

The AND, OR and XOR path reads the latch, not the pins. Plain reads return the pin levels after a two-stage synchronizer. Several such ports wired to one line form a wired-AND, because any port holding a 0 forces the line low.

Top module: `qb_port`

## Requirements
- R1: While reset is asserted and right after it is released, latchQ is 8'hFF, padOe is 8'h00, and (with the pull-up present) padPu is 8'hFF.
- R2: With wrByte high at a rising edge, latchQ equals wData after that edge. Bit 7 of wData is the most significant pin and bit 0 the least.
- R3: bitOp acts on the latch bit selected by bitIdx and leaves the other seven bits unchanged. The encodings are 2'b00 none, 2'b01 set, 2'b10 clear and 2'b11 invert.
- R4: Only one operation updates the latch per clock. The order of priority is byte write first, then bit operation, then the combining operation.
- R5: rmwOp combines operand with the current latch value, never with the pin levels, and stores the result in one clock. The encodings are 2'b00 none, 2'b01 AND, 2'b10 OR and 2'b11 XOR.
- R6: While rdPin is 1, pinData shows the synchronized pin levels and pinBit shows the synchronized level of pin bitIdx. While rdPin is 0, both read 0.
- R7: A change on padIn shows on pinData after the second rising edge, not after the first.
- R8: Reading the pins never changes the latch. A released pin that an outside device holds low reads 0, while its latch bit stays 1.
- R9: padOe bit i is 1, meaning the pin is driven hard low, exactly when latch bit i is 0.
- R10: With HAS_PULLUP=1, padPu bit i follows latch bit i, so a released pin is weakly pulled high. With HAS_PULLUP=0, padPu is all zeros and a released pin floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrByte | input | 1 | Byte write strobe |
| wData | input | WIDTH | Byte write data |
| bitOp | input | 2 | Single-bit operation code |
| bitIdx | input | IDXW | Bit index for bit operations and bit reads |
| rmwOp | input | 2 | Latch combining operation code |
| operand | input | WIDTH | Operand for the combining operation |
| rdPin | input | 1 | Pin read enable |
| pinData | output | WIDTH | Synchronized pin levels |
| pinBit | output | 1 | Synchronized level of pin bitIdx |
| latchQ | output | WIDTH | Output latch contents |
| padIn | input | WIDTH | Resolved pad levels |
| padOe | output | WIDTH | Per-pin hard-low drive enable |
| padPu | output | WIDTH | Per-pin weak pull-up enable |

## Verification
A corrupted latch bit shows on latchQ and padOe one edge after the operation that caused it. It also shows two edges later in the pin readback, because that pin then reads low. A combining operation that took its input from the pins instead of the latch only shows up when an outside device holds released pins low, so the bench drives pins low during those operations. A synchronizer that is one stage too short or too long shifts the readback by one clock, so the bench samples pinData after each of the two edges that follow a pad change.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;

  typedef enum logic [1:0] {
    BIT_NONE = 2'b00,
    BIT_SET  = 2'b01,
    BIT_CLR  = 2'b10,
    BIT_INV  = 2'b11
  } bit_op_e;

  typedef enum logic [1:0] {
    RMW_NONE = 2'b00,
    RMW_AND  = 2'b01,
    RMW_OR   = 2'b10,
    RMW_XOR  = 2'b11
  } rmw_op_e;

  typedef struct packed {
    logic       ldByte;
    logic       ldBit;
    logic       ldRmw;
    logic [1:0] bitKind;
    logic [1:0] rmwKind;
  } strobe_t;

endpackage

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl
  import qb_port_pkg::*;
(
  input  logic       wrByte,
  input  logic [1:0] bitOp,
  input  logic [1:0] rmwOp,
  output strobe_t    stb
);

  always_comb begin
    stb = '0;
    if (wrByte) begin
      stb.ldByte = 1'b1;
    end else if (bitOp != BIT_NONE) begin
      stb.ldBit   = 1'b1;
      stb.bitKind = bitOp;
    end else if (rmwOp != RMW_NONE) begin
      stb.ldRmw   = 1'b1;
      stb.rmwKind = rmwOp;
    end
  end

  always_comb begin
    // R4
    one_update_chk: assert ($onehot0({stb.ldByte, stb.ldBit, stb.ldRmw}));
    // R4
    byte_wins_chk: assert (!wrByte || (stb.ldByte && !stb.ldBit && !stb.ldRmw));
  end

endmodule

// File: rtl/qb_port_dp.sv
module qb_port_dp
  import qb_port_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int IDXW       = 3,
  parameter bit HAS_PULLUP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] wData,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic [WIDTH-1:0] operand,
  input  logic             rdPin,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] latchQ,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPu,
  output logic [WIDTH-1:0] pinData,
  output logic             pinBit
);

  localparam logic [WIDTH-1:0] ONE_LSB = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] latchR, latchNext, bitMask;
  logic [WIDTH-1:0] syncA, syncB;
  logic [1:0]       upCnt;

  assign bitMask = ONE_LSB << bitIdx;

  always_comb begin
    latchNext = latchR;
    if (stb.ldByte) begin
      latchNext = wData;
    end else if (stb.ldBit) begin
      unique case (stb.bitKind)
        BIT_SET: latchNext = latchR | bitMask;
        BIT_CLR: latchNext = latchR & ~bitMask;
        BIT_INV: latchNext = latchR ^ bitMask;
        default: latchNext = latchR;
      endcase
    end else if (stb.ldRmw) begin
      unique case (stb.rmwKind)
        RMW_AND: latchNext = latchR & operand;
        RMW_OR:  latchNext = latchR | operand;
        RMW_XOR: latchNext = latchR ^ operand;
        default: latchNext = latchR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latchR <= '1;
    else        latchR <= latchNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '1;
      syncB <= '1;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              upCnt <= '0;
    else if (upCnt != 2'd2)  upCnt <= upCnt + 2'd1;
  end

  assign latchQ  = latchR;
  assign padOe   = ~latchR;
  assign pinData = rdPin ? syncB : '0;
  assign pinBit  = rdPin & syncB[bitIdx];

  generate
    if (HAS_PULLUP) begin : g_pull
      assign padPu = latchR;
    end else begin : g_float
      assign padPu = '0;
    end
  endgenerate

  // R2
  byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.ldByte |=> latchR == $past(wData));

  // R3
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.ldBit |=> $countones(latchR ^ $past(latchR)) <= 1);

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.ldByte || stb.ldBit || stb.ldRmw) |=> $stable(latchR));

  // R7
  two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd2) |-> syncB == $past(padIn, 2));

endmodule

// File: rtl/qb_port.sv
module qb_port
  import qb_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit HAS_PULLUP  = 1'b1,
  localparam int IDXW       = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrByte,
  input  logic [WIDTH-1:0] wData,
  input  logic [1:0]       bitOp,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic [1:0]       rmwOp,
  input  logic [WIDTH-1:0] operand,
  input  logic             rdPin,
  output logic [WIDTH-1:0] pinData,
  output logic             pinBit,
  output logic [WIDTH-1:0] latchQ,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPu
);

  strobe_t stb;

  qb_port_ctrl u_ctrl (
    .wrByte (wrByte),
    .bitOp  (bitOp),
    .rmwOp  (rmwOp),
    .stb    (stb)
  );

  qb_port_dp #(
    .WIDTH      (WIDTH),
    .IDXW       (IDXW),
    .HAS_PULLUP (HAS_PULLUP)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .wData   (wData),
    .bitIdx  (bitIdx),
    .operand (operand),
    .rdPin   (rdPin),
    .padIn   (padIn),
    .latchQ  (latchQ),
    .padOe   (padOe),
    .padPu   (padPu),
    .pinData (pinData),
    .pinBit  (pinBit)
  );

endmodule

// File: tb/qb_port_test.sv
module qb_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrByte = 1'b0;
  logic [7:0] wData = '0;
  logic [1:0] bitOp = '0;
  logic [2:0] bitIdx = '0;
  logic [1:0] rmwOp = '0;
  logic [7:0] operand = '0;
  logic       rdPin = 1'b0;
  logic [7:0] extLow = '0;
  logic [7:0] pinData, latchQ, padIn, padOe, padPu;
  logic       pinBit;
  logic [7:0] pinData2, latchQ2, padOe2, padPu2;
  logic       pinBit2;

  always #10 clk = ~clk;

  // Board model: any driver holding low wins, otherwise the pull-up gives 1.
  assign padIn = ~padOe & ~extLow;

  qb_port uut (
    .clk(clk), .rst_n(rst_n), .wrByte(wrByte), .wData(wData), .bitOp(bitOp),
    .bitIdx(bitIdx), .rmwOp(rmwOp), .operand(operand), .rdPin(rdPin),
    .pinData(pinData), .pinBit(pinBit), .latchQ(latchQ), .padIn(padIn),
    .padOe(padOe), .padPu(padPu)
  );

  qb_port #(.HAS_PULLUP(1'b0)) uutNoPull (
    .clk(clk), .rst_n(rst_n), .wrByte(wrByte), .wData(wData), .bitOp(bitOp),
    .bitIdx(bitIdx), .rmwOp(rmwOp), .operand(operand), .rdPin(rdPin),
    .pinData(pinData2), .pinBit(pinBit2), .latchQ(latchQ2), .padIn(~padOe2),
    .padOe(padOe2), .padPu(padPu2)
  );

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;

  item_t      sbq[$];
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;
  logic [7:0] mLatch = 8'hFF;

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: return latchQ;
      1: return pinData;
      2: return padOe;
      3: return {7'b0, pinBit};
      4: return padPu;
      default: return padPu2;
    endcase
  endfunction

  function automatic void push(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sbq.push_back(it);
  endfunction

  // Monitor: compares each queued expectation 5 ns after the edge
  always @(posedge clk) begin
    #5;
    while (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      act = pick(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  function automatic logic [7:0] model(logic wb, logic [7:0] wd, logic [1:0] bo,
                                       logic [2:0] bi, logic [1:0] ro, logic [7:0] od);
    logic [7:0] m;
    m = 8'h01 << bi;
    if (wb) return wd;
    case (bo)
      2'b01: return mLatch | m;
      2'b10: return mLatch & ~m;
      2'b11: return mLatch ^ m;
      default: ;
    endcase
    case (ro)
      2'b01: return mLatch & od;
      2'b10: return mLatch | od;
      2'b11: return mLatch ^ od;
      default: return mLatch;
    endcase
  endfunction

  task automatic op(input logic wb, input logic [7:0] wd, input logic [1:0] bo,
                    input logic [2:0] bi, input logic [1:0] ro, input logic [7:0] od,
                    input string req);
    @(negedge clk);
    wrByte = wb; wData = wd; bitOp = bo; bitIdx = bi; rmwOp = ro; operand = od;
    @(posedge clk);
    mLatch = model(wb, wd, bo, bi, ro, od);
    push(req, 0, mLatch);
    push("R9", 2, ~mLatch);
    push("R10", 4, mLatch);
    push("R10", 5, 8'h00);
    @(negedge clk);
    wrByte = 1'b0; bitOp = '0; rmwOp = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    @(posedge clk);
    push("R1", 0, 8'hFF);
    push("R1", 2, 8'h00);
    push("R1", 4, 8'hFF);
    push("R1", 5, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2: byte write, MSB-first bit order
    op(1, 8'h5E, 0, 0, 0, 0, "R2");
    op(1, 8'h80, 0, 0, 0, 0, "R2");
    op(1, 8'h5E, 0, 0, 0, 0, "R2");

    // R3: set, clear, invert of single bits
    op(0, 0, 2'b01, 3'd0, 0, 0, "R3");
    op(0, 0, 2'b10, 3'd6, 0, 0, "R3");
    op(0, 0, 2'b11, 3'd3, 0, 0, "R3");
    op(0, 0, 2'b11, 3'd3, 0, 0, "R3");
    op(0, 0, 2'b10, 3'd7, 0, 0, "R3");

    // R4: priority byte > bit > combine
    op(1, 8'hA5, 2'b01, 3'd1, 2'b11, 8'hFF, "R4");
    op(0, 0, 2'b10, 3'd0, 2'b10, 8'hFF, "R4");

    // R5: combine reads the latch while pins are held low outside
    op(1, 8'hF0, 0, 0, 0, 0, "R5");
    @(negedge clk); extLow = 8'hFF;
    op(0, 0, 0, 0, 2'b10, 8'h0F, "R5");
    op(0, 0, 0, 0, 2'b01, 8'h3C, "R5");
    op(0, 0, 0, 0, 2'b11, 8'hFF, "R5");
    @(negedge clk); extLow = 8'h00;
    idle(3);

    // R7 / R8 / R6: pin path
    op(1, 8'hFF, 0, 0, 0, 0, "R2");
    idle(3);
    @(negedge clk);
    rdPin = 1'b1; extLow = 8'h81;
    @(posedge clk);
    push("R7", 1, 8'hFF);
    @(posedge clk);
    push("R7", 1, 8'h7E);
    push("R8", 0, 8'hFF);
    @(negedge clk); bitIdx = 3'd0;
    @(posedge clk); push("R6", 3, 8'h00);
    @(negedge clk); bitIdx = 3'd1;
    @(posedge clk); push("R6", 3, 8'h01);
    push("R8", 0, 8'hFF);
    @(negedge clk); rdPin = 1'b0;
    @(posedge clk); push("R6", 1, 8'h00); push("R6", 3, 8'h00);
    @(negedge clk); rdPin = 1'b1; extLow = 8'h00;
    op(1, 8'h3C, 0, 0, 0, 0, "R9");
    idle(2);
    @(posedge clk); push("R6", 1, 8'h3C);
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule